// File: doc/BRIEF.md
# Receive Frame Buffer Mover

This block carries one received Ethernet frame out of the MAC receive byte FIFO and into a packet buffer. When the MAC announces a new reception, the block asks the memory manager for a buffer. It then copies the frame bytes into that buffer through an arbitrated write port, keeping its own byte counter as it goes. When the frame is complete, it writes the length word into the buffer header and hands the packet number to a CPU-facing queue.

The block gives the buffer back to the memory manager instead of queueing it in three cases: the address filter rejects the frame, the CRC is bad and keeping bad frames is not enabled, or the frame grows beyond the length limit. In the last case it also raises an abort flag. If allocation fails, it writes nothing and simply waits for the frame to end, so that it can accept the next frame. Only one frame is handled at a time.

Top module: `rx_frame_dma`

## Requirements
- R1: A one-cycle `mac_rx_start` pulse seen while idle raises `mmu_alloc_req`, which stays high until `mmu_alloc_ack`. A start pulse seen while a frame is in progress is ignored, so exactly one allocation is made per frame.
- R2: After a successful allocation (`mmu_alloc_ok`=1 with the ack), data byte k (counted from 0) is written in arrival order with `mem_wr_word`=0, address HDR_BYTES+k (4+k by default) and the byte in `mem_wr_data[7:0]`. A write is requested only while the FIFO is not empty, and `mac_fifo_pop` is high exactly in the cycles where a data write is granted.
- R3: If allocation fails, the block makes no memory write, no release and no queue push. A later start pulse, after `mac_frame_end`, is accepted again.
- R4: A filter result with `filt_valid`=1 and `filt_hit`=0 makes the block release the stored packet number through `mmu_rel_req`/`mmu_rel_pkt`. It then makes no length write and no queue push.
- R5: A frame that completes with good CRC gets one word write (`mem_wr_word`=1) at address CNT_OFS (2 by default), with data equal to the number of data bytes plus HDR_BYTES. After that write, the stored packet number is pushed through `rxq_push_req`/`rxq_push_pkt`, and no release is made.
- R6: A frame that completes with bad CRC while `cfg_keep_bad_crc`=0 is released, with no length write and no queue push.
- R7: With `cfg_keep_bad_crc`=1, a bad-CRC frame is length-written and queued exactly like a good one.
- R8: If a byte is waiting while MAX_BYTES data bytes have already been written, that byte is not written. `rx_abort` is set and the buffer is released. `rx_abort` stays set until the next accepted start. A frame of exactly MAX_BYTES bytes completes normally.
- R9: A frame completes only once the end-of-frame pulse and the filter result have both been seen and the FIFO is empty. Bytes still in the FIFO when `mac_frame_end` arrives are still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mac_rx_start | input | 1 | Pulse: a reception has begun |
| mac_fifo_empty | input | 1 | MAC receive FIFO has no byte |
| mac_fifo_data | input | 8 | Byte at the FIFO head |
| mac_fifo_pop | output | 1 | Head byte consumed this cycle |
| filt_valid | input | 1 | Pulse: address filter result |
| filt_hit | input | 1 | Filter result: address matched |
| mac_frame_end | input | 1 | Pulse: frame finished |
| mac_crc_good | input | 1 | CRC status, valid with the end pulse |
| cfg_keep_bad_crc | input | 1 | Queue bad-CRC frames too |
| mmu_alloc_req | output | 1 | Buffer allocation request |
| mmu_alloc_ack | input | 1 | Allocation answered |
| mmu_alloc_ok | input | 1 | Allocation succeeded |
| mmu_alloc_pkt | input | PKT_W | Granted packet number |
| mmu_rel_req | output | 1 | Buffer release request |
| mmu_rel_pkt | output | PKT_W | Packet number to free |
| mmu_rel_ack | input | 1 | Release accepted |
| mem_wr_req | output | 1 | Arbitrated write request |
| mem_wr_gnt | input | 1 | Write granted this cycle |
| mem_wr_addr | output | ADDR_W | Byte offset inside the buffer |
| mem_wr_data | output | 16 | Write data |
| mem_wr_word | output | 1 | 1: 16-bit length word, 0: one byte |
| rxq_push_req | output | 1 | Push packet number to CPU queue |
| rxq_push_pkt | output | PKT_W | Packet number pushed |
| rxq_push_ack | input | 1 | Push accepted |
| rx_abort | output | 1 | Oversize abort flag |

## Verification
The bench builds the block with MAX_BYTES=40 and PKT_W=6, keeping ADDR_W at 11. The low length limit means that frames of exactly 40 bytes, and frames just over the limit, can be reached in a few hundred cycles, so both the boundary and the abort path are run many times. The 6-bit packet number makes each granted number distinct enough to tell a release of the wrong buffer apart from a release of the right one. Random grant and ack delays make the end-of-frame pulse arrive while bytes are still waiting in the FIFO.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ALLOC = 3'd1,
        ST_XFER  = 3'd2,
        ST_CNT   = 3'd3,
        ST_QUEUE = 3'd4,
        ST_REL   = 3'd5,
        ST_WAIT  = 3'd6
    } rx_st_e;
endpackage

// File: rtl/rxdma_byte_ctr.sv
module rxdma_byte_ctr #(
    parameter int CW        = 11,
    parameter int MAX_BYTES = 1532
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count,
    output logic          at_limit
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count    = cnt_q;
    assign at_limit = (cnt_q == CW'(MAX_BYTES));

    // R8
    ctr_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAX_BYTES));

    // R2
    ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> cnt_q == $past(cnt_q) + CW'(1));
endmodule

// File: rtl/rxdma_wr_path.sv
module rxdma_wr_path #(
    parameter int AW        = 11,
    parameter int HDR_BYTES = 4,
    parameter int CNT_OFS   = 2
) (
    input  logic          data_req,
    input  logic          cnt_req,
    input  logic [7:0]    fifo_data,
    input  logic [AW-1:0] count,
    input  logic          gnt,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [15:0]   wr_data,
    output logic          wr_word,
    output logic          fifo_pop
);
    always_comb begin
        wr_req   = data_req | cnt_req;
        wr_word  = cnt_req;
        fifo_pop = data_req & gnt;
        if (cnt_req) begin
            wr_addr = AW'(CNT_OFS);
            wr_data = 16'(count) + 16'(HDR_BYTES);
        end else begin
            wr_addr = AW'(HDR_BYTES) + count;
            wr_data = {8'h00, fifo_data};
        end
    end
endmodule

// File: rtl/rxdma_ctrl.sv
module rxdma_ctrl
    import rxdma_pkg::*;
#(
    parameter int PKT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             fifo_empty,
    input  logic             filt_vld,
    input  logic             filt_hit,
    input  logic             frame_end,
    input  logic             crc_good,
    input  logic             keep_bad,
    input  logic             alloc_ack,
    input  logic             alloc_ok,
    input  logic [PKT_W-1:0] alloc_pkt,
    input  logic             rel_ack,
    input  logic             push_ack,
    input  logic             wr_gnt,
    input  logic             at_limit,
    output logic             alloc_req,
    output logic             rel_req,
    output logic             push_req,
    output logic [PKT_W-1:0] pkt,
    output logic             abort,
    output logic             ctr_clr,
    output logic             ctr_inc,
    output logic             data_req,
    output logic             cnt_req
);
    typedef struct packed {
        rx_st_e           st;
        logic [PKT_W-1:0] pkt;
        logic             abort;
        logic             done;
        logic             crc;
        logic             mseen;
        logic             mok;
    } ctrl_s;

    ctrl_s r_d, r_q;
    logic  done_now, crc_now, mseen_now, mok_now;

    always_comb begin
        r_d       = r_q;
        alloc_req = 1'b0;
        rel_req   = 1'b0;
        push_req  = 1'b0;
        ctr_clr   = 1'b0;
        ctr_inc   = 1'b0;
        data_req  = 1'b0;
        cnt_req   = 1'b0;
        done_now  = r_q.done | frame_end;
        crc_now   = frame_end ? crc_good : r_q.crc;
        mseen_now = r_q.mseen | filt_vld;
        mok_now   = filt_vld ? filt_hit : r_q.mok;
        if (r_q.st != ST_IDLE) begin
            r_d.done  = done_now;
            r_d.crc   = crc_now;
            r_d.mseen = mseen_now;
            r_d.mok   = mok_now;
        end
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st    = ST_ALLOC;
                    r_d.abort = 1'b0;
                    r_d.done  = 1'b0;
                    r_d.crc   = 1'b0;
                    r_d.mseen = 1'b0;
                    r_d.mok   = 1'b0;
                    ctr_clr   = 1'b1;
                end
            end
            ST_ALLOC: begin
                alloc_req = 1'b1;
                if (alloc_ack) begin
                    if (alloc_ok) begin
                        r_d.pkt = alloc_pkt;
                        r_d.st  = ST_XFER;
                    end else begin
                        r_d.st  = done_now ? ST_IDLE : ST_WAIT;
                    end
                end
            end
            ST_XFER: begin
                if (mseen_now && !mok_now) begin
                    r_d.st = ST_REL;
                end else if (!fifo_empty && at_limit) begin
                    r_d.abort = 1'b1;
                    r_d.st    = ST_REL;
                end else if (!fifo_empty) begin
                    data_req = 1'b1;
                    ctr_inc  = wr_gnt;
                end else if (done_now && mseen_now) begin
                    r_d.st = (crc_now || keep_bad) ? ST_CNT : ST_REL;
                end
            end
            ST_CNT: begin
                cnt_req = 1'b1;
                if (wr_gnt) r_d.st = ST_QUEUE;
            end
            ST_QUEUE: begin
                push_req = 1'b1;
                if (push_ack) r_d.st = ST_IDLE;
            end
            ST_REL: begin
                rel_req = 1'b1;
                if (rel_ack) r_d.st = done_now ? ST_IDLE : ST_WAIT;
            end
            ST_WAIT: begin
                if (done_now) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, pkt: '0, abort: 1'b0, done: 1'b0,
                     crc: 1'b0, mseen: 1'b0, mok: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign pkt   = r_q.pkt;
    assign abort = r_q.abort;

    // R1
    alloc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && !alloc_ack) |=> alloc_req);

    // R1
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && r_q.st != ST_IDLE) |=> !ctr_clr);

    // R4
    no_match_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_XFER && filt_vld && !filt_hit) |=> rel_req);

    // R6
    one_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rel_req && push_req));

    // R8
    abort_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort) |-> rel_req);

    // R2
    write_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_req |-> !fifo_empty);
endmodule

// File: rtl/rx_frame_dma.sv
module rx_frame_dma #(
    parameter int ADDR_W    = 11,
    parameter int PKT_W     = 6,
    parameter int MAX_BYTES = 1532,
    parameter int HDR_BYTES = 4,
    parameter int CNT_OFS   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mac_rx_start,
    input  logic              mac_fifo_empty,
    input  logic [7:0]        mac_fifo_data,
    output logic              mac_fifo_pop,
    input  logic              filt_valid,
    input  logic              filt_hit,
    input  logic              mac_frame_end,
    input  logic              mac_crc_good,
    input  logic              cfg_keep_bad_crc,
    output logic              mmu_alloc_req,
    input  logic              mmu_alloc_ack,
    input  logic              mmu_alloc_ok,
    input  logic [PKT_W-1:0]  mmu_alloc_pkt,
    output logic              mmu_rel_req,
    output logic [PKT_W-1:0]  mmu_rel_pkt,
    input  logic              mmu_rel_ack,
    output logic              mem_wr_req,
    input  logic              mem_wr_gnt,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [15:0]       mem_wr_data,
    output logic              mem_wr_word,
    output logic              rxq_push_req,
    output logic [PKT_W-1:0]  rxq_push_pkt,
    input  logic              rxq_push_ack,
    output logic              rx_abort
);
    localparam int CW = ADDR_W;

    logic             ctr_clr, ctr_inc, at_limit, data_req, cnt_req;
    logic [CW-1:0]    count;
    logic [PKT_W-1:0] pkt;

    rxdma_ctrl #(.PKT_W(PKT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (mac_rx_start),
        .fifo_empty(mac_fifo_empty),
        .filt_vld  (filt_valid),
        .filt_hit  (filt_hit),
        .frame_end (mac_frame_end),
        .crc_good  (mac_crc_good),
        .keep_bad  (cfg_keep_bad_crc),
        .alloc_ack (mmu_alloc_ack),
        .alloc_ok  (mmu_alloc_ok),
        .alloc_pkt (mmu_alloc_pkt),
        .rel_ack   (mmu_rel_ack),
        .push_ack  (rxq_push_ack),
        .wr_gnt    (mem_wr_gnt),
        .at_limit  (at_limit),
        .alloc_req (mmu_alloc_req),
        .rel_req   (mmu_rel_req),
        .push_req  (rxq_push_req),
        .pkt       (pkt),
        .abort     (rx_abort),
        .ctr_clr   (ctr_clr),
        .ctr_inc   (ctr_inc),
        .data_req  (data_req),
        .cnt_req   (cnt_req)
    );

    rxdma_byte_ctr #(.CW(CW), .MAX_BYTES(MAX_BYTES)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ctr_clr),
        .inc     (ctr_inc),
        .count   (count),
        .at_limit(at_limit)
    );

    rxdma_wr_path #(.AW(ADDR_W), .HDR_BYTES(HDR_BYTES), .CNT_OFS(CNT_OFS)) u_wr (
        .data_req (data_req),
        .cnt_req  (cnt_req),
        .fifo_data(mac_fifo_data),
        .count    (count),
        .gnt      (mem_wr_gnt),
        .wr_req   (mem_wr_req),
        .wr_addr  (mem_wr_addr),
        .wr_data  (mem_wr_data),
        .wr_word  (mem_wr_word),
        .fifo_pop (mac_fifo_pop)
    );

    assign mmu_rel_pkt  = pkt;
    assign rxq_push_pkt = pkt;

    // R5
    cnt_then_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && mem_wr_word && mem_wr_gnt) |=> rxq_push_req);
endmodule

// File: tb/rx_frame_dma_bench.sv
module rx_frame_dma_bench;
    localparam int AW = 11, PW = 6, MAXB = 40, HDR = 4, COFS = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic mac_rx_start = 0, mac_fifo_empty = 1, filt_valid = 0, filt_hit = 0;
    logic mac_frame_end = 0, mac_crc_good = 0, cfg_keep_bad_crc = 0;
    logic [7:0] mac_fifo_data = 0;
    logic mmu_alloc_ack = 0, mmu_alloc_ok = 0, mmu_rel_ack = 0;
    logic mem_wr_gnt = 0, rxq_push_ack = 0;
    logic [PW-1:0] mmu_alloc_pkt = 0;
    logic mac_fifo_pop, mmu_alloc_req, mmu_rel_req, mem_wr_req, mem_wr_word;
    logic rxq_push_req, rx_abort;
    logic [PW-1:0] mmu_rel_pkt, rxq_push_pkt;
    logic [AW-1:0] mem_wr_addr;
    logic [15:0] mem_wr_data;

    rx_frame_dma #(.ADDR_W(AW), .PKT_W(PW), .MAX_BYTES(MAXB),
                   .HDR_BYTES(HDR), .CNT_OFS(COFS)) u_rx_frame_dma (.*);

    always #5 clk = ~clk;

    int n_chk = 0, n_err = 0;
    logic [7:0] q[$];
    logic [7:0] sent [0:127];
    int wr_addr [0:127];
    int wr_data [0:127];
    int nw, n_cnt, cnt_addr, cnt_val, n_alloc, n_rel, n_push;
    int alloc_pkt_s, rel_pkt_s, push_pkt_s;
    bit cur_ok, pend_pop;

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_len_word(int n);
        return n + HDR;
    endfunction

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic sync_fifo();
        mac_fifo_empty = (q.size() == 0);
        mac_fifo_data  = (q.size() == 0) ? 8'h00 : q[0];
    endtask

    // responder models: memory, MMU, arbiter, queue
    initial begin
        pend_pop = 0;
        forever begin
            @(posedge clk); #1;
            if (pend_pop && q.size() > 0) void'(q.pop_front());
            pend_pop = 0;
            sync_fifo();
            @(negedge clk);
            mem_wr_gnt    = ($urandom % 3) != 0;
            mmu_alloc_ack = mmu_alloc_req && ($urandom % 2);
            mmu_alloc_ok  = cur_ok;
            mmu_alloc_pkt = PW'($urandom);
            mmu_rel_ack   = mmu_rel_req && ($urandom % 2);
            rxq_push_ack  = rxq_push_req && ($urandom % 2);
            #1;
            if (mem_wr_req && mem_wr_gnt) begin
                if (mem_wr_word) begin
                    n_cnt++; cnt_addr = int'(mem_wr_addr); cnt_val = int'(mem_wr_data);
                end else if (nw < 128) begin
                    wr_addr[nw] = int'(mem_wr_addr); wr_data[nw] = int'(mem_wr_data); nw++;
                end
            end
            if (mac_fifo_pop) pend_pop = 1;
            if (mmu_alloc_req && mmu_alloc_ack) begin
                n_alloc++; if (cur_ok) alloc_pkt_s = int'(mmu_alloc_pkt);
            end
            if (mmu_rel_req && mmu_rel_ack) begin n_rel++; rel_pkt_s = int'(mmu_rel_pkt); end
            if (rxq_push_req && rxq_push_ack) begin n_push++; push_pkt_s = int'(rxq_push_pkt); end
        end
    end

    task automatic run_frame(int n, bit a_ok, bit hit, bit crc, bit keep, bit dup);
        int fpos, mism, expn;
        nw = 0; n_cnt = 0; n_alloc = 0; n_rel = 0; n_push = 0;
        alloc_pkt_s = -1; rel_pkt_s = -2; push_pkt_s = -3;
        cur_ok = a_ok; cfg_keep_bad_crc = keep;
        fpos = (n > 1) ? 1 : 0;
        tick(); mac_rx_start = 1;
        tick(); mac_rx_start = 0;
        // R8: abort flag cleared by the accepted start
        chk(rx_abort == 1'b0, "R8 abort cleared on start", rx_abort, 0);
        for (int i = 0; i < n; i++) begin
            tick();
            filt_valid = 0;
            if ($urandom % 2) begin tick(); end
            sent[i % 128] = 8'($urandom);
            q.push_back(sent[i % 128]);
            sync_fifo();
            if (i == fpos) begin filt_valid = 1; filt_hit = hit; end
        end
        tick(); filt_valid = 0;
        mac_frame_end = 1; mac_crc_good = crc;
        if (dup) mac_rx_start = 1;
        tick(); mac_frame_end = 0; mac_rx_start = 0;
        for (int t = 0; t < 600; t++) begin
            if (a_ok && (n_push + n_rel) > 0) break;
            if (!a_ok && n_alloc > 0) break;
            tick();
        end
        repeat (4) tick();
        q.delete(); sync_fifo();
        repeat (2) tick();

        // R1: one allocation per frame, duplicate start ignored
        chk(n_alloc == 1, "R1 allocations per frame", n_alloc, 1);
        if (!a_ok) begin
            // R3
            chk(nw == 0 && n_cnt == 0, "R3 no write after failed alloc", nw + n_cnt, 0);
            chk(n_rel == 0 && n_push == 0, "R3 no release/push after failed alloc", n_rel + n_push, 0);
        end else if (!hit) begin
            // R4
            chk(n_rel == 1 && rel_pkt_s == alloc_pkt_s, "R4 release of stored pkt on no match", rel_pkt_s, alloc_pkt_s);
            chk(n_push == 0 && n_cnt == 0, "R4 no length write or push", n_push + n_cnt, 0);
        end else begin
            expn = (n > MAXB) ? MAXB : n;
            mism = 0;
            for (int k = 0; k < expn && k < 128; k++)
                if (wr_addr[k] != HDR + k || wr_data[k] != int'(sent[k])) mism++;
            // R2 / R9: every byte written in order, including those left after frame end
            chk(nw == expn, "R9 byte writes count", nw, expn);
            chk(mism == 0, "R2 byte address/data", mism, 0);
            if (n > MAXB) begin
                // R8
                chk(rx_abort == 1'b1, "R8 abort flag", rx_abort, 1);
                chk(n_rel == 1 && rel_pkt_s == alloc_pkt_s && n_push == 0, "R8 oversize release", rel_pkt_s, alloc_pkt_s);
            end else if (crc || keep) begin
                // R5, R7 for kept bad frames
                chk(n_cnt == 1 && cnt_addr == COFS, crc ? "R5 length word address" : "R7 length word address", cnt_addr, COFS);
                chk(cnt_val == exp_len_word(n), crc ? "R5 length word value" : "R7 length word value", cnt_val, exp_len_word(n));
                chk(n_push == 1 && push_pkt_s == alloc_pkt_s && n_rel == 0, crc ? "R5 queue push" : "R7 queue push", push_pkt_s, alloc_pkt_s);
                chk(rx_abort == 1'b0, "R8 no abort within limit", rx_abort, 0);
            end else begin
                // R6
                chk(n_rel == 1 && rel_pkt_s == alloc_pkt_s, "R6 bad CRC release", rel_pkt_s, alloc_pkt_s);
                chk(n_push == 0 && n_cnt == 0, "R6 no push or length write", n_push + n_cnt, 0);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #2;
        chk(!mmu_alloc_req && !mem_wr_req && !mmu_rel_req && !rxq_push_req && !rx_abort,
            "R1 idle outputs after reset", mmu_alloc_req, 0);
        rst_n = 1;
        tick();
        chk(!mmu_alloc_req, "R1 no request without start", mmu_alloc_req, 0);
        // directed corners
        run_frame(1,        1, 1, 1, 0, 0);
        run_frame(MAXB,     1, 1, 1, 0, 0);
        run_frame(MAXB + 1, 1, 1, 1, 0, 0);
        run_frame(10,       1, 1, 1, 0, 0);   // abort flag cleared again
        run_frame(MAXB + 6, 1, 1, 0, 1, 0);
        run_frame(12,       0, 1, 1, 0, 0);
        run_frame(8,        1, 1, 1, 0, 0);   // R3: accepted after failure
        run_frame(9,        1, 0, 1, 0, 0);
        run_frame(7,        1, 1, 0, 0, 0);
        run_frame(7,        1, 1, 0, 1, 1);
        // random frames
        for (int f = 0; f < 40; f++) begin
            int n, sel;
            sel = $urandom % 10;
            n = 1 + ($urandom % (MAXB + 4));
            run_frame(n, sel != 0, sel != 1, sel > 3, ($urandom % 2) == 1, ($urandom % 3) == 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule